// File: doc/BRIEF.md
# Prioritized Exception Entry Unit

This unit sits next to a processor core and decides which exception the core takes next. Seven request lines come in: reset, data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt and undefined instruction. Each cycle in which the core raises `accept_i`, the unit picks the most urgent request that is pending and not masked. It then emits the handler vector with a one-cycle strobe and switches the status word to the new mode. The old status word goes into that mode's banked saved-status register, and `ret_addr_i` goes into that mode's link register.

The status word holds two mask bits, three condition flags and a mode code. The mode code is also the register bank-select code that the core uses. An exception-return strobe copies the saved status back into the live status word, both mask bits included. Software can write the status word: privileged modes may change every field, while user mode may change only the condition flags.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the status word is 0xC3: bit 7 is the normal-interrupt mask I, bit 6 is the fast-interrupt mask F, bits 5:3 are flags and bits 2:0 are the mode (user 0, fast 1, irq 2, supervisor 3, abort 4, undefined 5). After reset `entry_o` is 0 and the saved status and link outputs read 0.
- R2: Priority runs from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort. Software interrupt and undefined instruction share the lowest level; when both are pending, undefined instruction is taken.
- R3: An entry registers `vector_o` = VEC_BASE + offset on the clock edge where it is accepted. The offsets are reset 0x00, undefined 0x04, software 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18 and fast interrupt 0x1C. `entry_o` is high for exactly that one cycle.
- R4: The entered mode is supervisor for reset and software interrupt, abort for both aborts, fast for the fast interrupt, irq for the normal interrupt and undefined for the undefined instruction.
- R5: On entry, the previous status word goes into the saved-status register of the entered mode and `ret_addr_i` goes into its link register. `saved_status_o` and `link_o` show the copies for the current mode; in user mode they read 0.
- R6: Every entry sets I to 1.
- R7: Only a fast-interrupt or reset entry sets F. Every other entry leaves F unchanged.
- R8: A fast request is ignored while F is 1, and a normal request is ignored while I is 1. The other five sources are never masked.
- R9: Requests are sampled only in cycles where `accept_i` is 1.
- R10: `exc_return_i` in a non-user mode loads the status word from the current mode's saved copy; in user mode it has no effect. An entry takes precedence over a return, and a return over a status write.
- R11: A status write (`sw_we_i`) in a privileged mode replaces the whole word. In user mode it changes only bits 5:3.
- R12: When data abort and fast interrupt arrive together, abort mode is entered first. On the next accept the fast interrupt is entered, and its saved status is the abort-mode status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| accept_i | input | 1 | Core ready to take an exception this cycle |
| req_reset_i | input | 1 | Reset request |
| req_data_abort_i | input | 1 | Data abort request |
| req_fast_irq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_prefetch_abort_i | input | 1 | Prefetch abort request |
| req_swi_i | input | 1 | Software interrupt request |
| req_undef_i | input | 1 | Undefined instruction request |
| ret_addr_i | input | ADDR_W | Return address for the link register |
| exc_return_i | input | 1 | Exception-return strobe |
| sw_we_i | input | 1 | Status write enable |
| sw_data_i | input | 8 | Status write data |
| entry_o | output | 1 | One-cycle entry strobe |
| vector_o | output | ADDR_W | Handler vector address |
| status_o | output | 8 | Live status word |
| bank_sel_o | output | 3 | Register bank-select code (mode) |
| saved_status_o | output | 8 | Saved status of the current mode |
| link_o | output | ADDR_W | Link register of the current mode |

## Verification
The assertions assume that any mode code written by software is one of the six defined codes. They also assume that a status write and a return are not issued in the same cycle as an accepted entry when the checked property concerns the write or the return. The stimulus writes only the values 0x03, 0x00 and 0xF8, so every mode it creates is defined. It raises `exc_return_i` and `sw_we_i` only in cycles where `accept_i` is low, which keeps each checked window free of competing updates.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STATUS_W = 8;
  localparam int MODE_W   = 3;
  localparam int NUM_SRC  = 7;
  localparam int SRC_W    = 3;
  localparam int NUM_BANKS = 6;
  localparam int I_BIT = 7;
  localparam int F_BIT = 6;

  localparam logic [MODE_W-1:0] MODE_USER = 3'd0;
  localparam logic [MODE_W-1:0] MODE_FAST = 3'd1;
  localparam logic [MODE_W-1:0] MODE_IRQ  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SUP  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_ABT  = 3'd4;
  localparam logic [MODE_W-1:0] MODE_UND  = 3'd5;

  // source index == priority rank, lowest index wins
  localparam logic [SRC_W-1:0] SRC_RESET = 3'd0;
  localparam logic [SRC_W-1:0] SRC_DABT  = 3'd1;
  localparam logic [SRC_W-1:0] SRC_FAST  = 3'd2;
  localparam logic [SRC_W-1:0] SRC_IRQ   = 3'd3;
  localparam logic [SRC_W-1:0] SRC_PABT  = 3'd4;
  localparam logic [SRC_W-1:0] SRC_UNDEF = 3'd5;
  localparam logic [SRC_W-1:0] SRC_SWI   = 3'd6;

  localparam logic [STATUS_W-1:0] STATUS_RESET = 8'hC3;

  function automatic logic [4:0] vec_offset(input logic [SRC_W-1:0] src);
    case (src)
      SRC_RESET: vec_offset = 5'h00;
      SRC_UNDEF: vec_offset = 5'h04;
      SRC_SWI:   vec_offset = 5'h08;
      SRC_PABT:  vec_offset = 5'h0C;
      SRC_DABT:  vec_offset = 5'h10;
      SRC_IRQ:   vec_offset = 5'h18;
      SRC_FAST:  vec_offset = 5'h1C;
      default:   vec_offset = 5'h14;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] src_mode(input logic [SRC_W-1:0] src);
    case (src)
      SRC_RESET, SRC_SWI:  src_mode = MODE_SUP;
      SRC_DABT, SRC_PABT:  src_mode = MODE_ABT;
      SRC_FAST:            src_mode = MODE_FAST;
      SRC_IRQ:             src_mode = MODE_IRQ;
      default:             src_mode = MODE_UND;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               mask_i_i,
  input  logic               mask_f_i,
  output logic               valid_o,
  output logic [SRC_W-1:0]   src_o
);
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    elig = req_i;
    elig[SRC_FAST] = req_i[SRC_FAST] & ~mask_f_i;
    elig[SRC_IRQ]  = req_i[SRC_IRQ] & ~mask_i_i;
  end

  always_comb begin
    src_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) src_o = SRC_W'(i);
    end
  end

  assign valid_o = |elig;
endmodule

// File: rtl/exc_bank_store.sv
module exc_bank_store
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [MODE_W-1:0]   wr_bank_i,
  input  logic [STATUS_W-1:0] wr_status_i,
  input  logic [ADDR_W-1:0]   wr_link_i,
  input  logic [MODE_W-1:0]   rd_bank_i,
  output logic [STATUS_W-1:0] rd_status_o,
  output logic [ADDR_W-1:0]   rd_link_o
);
  localparam int NB = NUM_BANKS - 1; // user mode has no bank

  logic [STATUS_W-1:0] saved_q [NB];
  logic [ADDR_W-1:0]   link_q  [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        saved_q[b] <= '0;
        link_q[b]  <= '0;
      end else if (wr_en_i && wr_bank_i == MODE_W'(b + 1)) begin
        saved_q[b] <= wr_status_i;
        link_q[b]  <= wr_link_i;
      end
    end
  end

  always_comb begin
    rd_status_o = '0;
    rd_link_o   = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_bank_i == MODE_W'(b + 1)) begin
        rd_status_o = saved_q[b];
        rd_link_o   = link_q[b];
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                req_reset_i,
  input  logic                req_data_abort_i,
  input  logic                req_fast_irq_i,
  input  logic                req_irq_i,
  input  logic                req_prefetch_abort_i,
  input  logic                req_swi_i,
  input  logic                req_undef_i,
  input  logic [ADDR_W-1:0]   ret_addr_i,
  input  logic                exc_return_i,
  input  logic                sw_we_i,
  input  logic [STATUS_W-1:0] sw_data_i,
  output logic                entry_o,
  output logic [ADDR_W-1:0]   vector_o,
  output logic [STATUS_W-1:0] status_o,
  output logic [MODE_W-1:0]   bank_sel_o,
  output logic [STATUS_W-1:0] saved_status_o,
  output logic [ADDR_W-1:0]   link_o
);
  logic [NUM_SRC-1:0]  req;
  logic                sel_valid;
  logic [SRC_W-1:0]    sel_src;
  logic                take;
  logic [MODE_W-1:0]   new_mode;
  logic [MODE_W-1:0]   cur_mode;
  logic                privileged;
  logic                bank_ok;
  logic                set_f;
  logic [STATUS_W-1:0] status_q, status_d;
  logic [STATUS_W-1:0] saved_rd;
  logic [ADDR_W-1:0]   link_rd;

  always_comb begin
    req = '0;
    req[SRC_RESET] = req_reset_i;
    req[SRC_DABT]  = req_data_abort_i;
    req[SRC_FAST]  = req_fast_irq_i;
    req[SRC_IRQ]   = req_irq_i;
    req[SRC_PABT]  = req_prefetch_abort_i;
    req[SRC_UNDEF] = req_undef_i;
    req[SRC_SWI]   = req_swi_i;
  end

  exc_prio_sel u_sel (
    .req_i    (req),
    .mask_i_i (status_q[I_BIT]),
    .mask_f_i (status_q[F_BIT]),
    .valid_o  (sel_valid),
    .src_o    (sel_src)
  );

  assign take       = accept_i & sel_valid;
  assign new_mode   = src_mode(sel_src);
  assign cur_mode   = status_q[MODE_W-1:0];
  assign privileged = (cur_mode != MODE_USER);
  assign bank_ok    = privileged && (cur_mode <= MODE_UND);
  assign set_f      = (sel_src == SRC_FAST) || (sel_src == SRC_RESET);

  exc_bank_store #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (take),
    .wr_bank_i   (new_mode),
    .wr_status_i (status_q),
    .wr_link_i   (ret_addr_i),
    .rd_bank_i   (cur_mode),
    .rd_status_o (saved_rd),
    .rd_link_o   (link_rd)
  );

  always_comb begin
    status_d = status_q;
    if (take) begin
      status_d = {1'b1, status_q[F_BIT] | set_f, status_q[5:3], new_mode};
    end else if (exc_return_i && bank_ok) begin
      status_d = saved_rd;
    end else if (sw_we_i) begin
      status_d = privileged ? sw_data_i
                            : {status_q[7:6], sw_data_i[5:3], status_q[2:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_RESET;
      entry_o  <= 1'b0;
      vector_o <= VEC_BASE;
    end else begin
      status_q <= status_d;
      entry_o  <= take;
      if (take) vector_o <= VEC_BASE + ADDR_W'(vec_offset(sel_src));
    end
  end

  assign status_o       = status_q;
  assign bank_sel_o     = cur_mode;
  assign saved_status_o = saved_rd;
  assign link_o         = link_rd;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              accept_i,
  input logic              req_reset_i,
  input logic              req_data_abort_i,
  input logic              req_fast_irq_i,
  input logic              req_irq_i,
  input logic              req_prefetch_abort_i,
  input logic              req_swi_i,
  input logic              req_undef_i,
  input logic [ADDR_W-1:0] ret_addr_i,
  input logic              exc_return_i,
  input logic              sw_we_i,
  input logic              entry_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [7:0]        status_o,
  input logic [7:0]        saved_status_o,
  input logic [ADDR_W-1:0] link_o
);
  logic others;
  assign others = req_reset_i | req_data_abort_i | req_irq_i |
                  req_prefetch_abort_i | req_swi_i | req_undef_i;

  assert_entry_needs_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> $past(accept_i));

  assert_entry_sets_i_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> status_o[7]);

  assert_fast_entry_sets_f_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_o && vector_o == VEC_BASE + ADDR_W'(28)) |-> status_o[6]);

  assert_other_entry_keeps_f_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_o && vector_o != VEC_BASE + ADDR_W'(28) && vector_o != VEC_BASE)
      |-> status_o[6] == $past(status_o[6]));

  assert_link_captured_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> link_o == $past(ret_addr_i));

  assert_masked_fast_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && req_fast_irq_i && status_o[6] && !others) |=> !entry_o);

  assert_user_write_keeps_masks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2:0] == 3'd0 && sw_we_i && !accept_i && !exc_return_i)
      |=> $stable(status_o[7:6]));

  assert_return_restores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_return_i && !accept_i && status_o[2:0] != 3'd0 && status_o[2:0] <= 3'd5)
      |=> status_o == $past(saved_status_o));
endmodule

bind exc_entry_unit exc_entry_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk_i                (clk_i),
  .rst_ni               (rst_ni),
  .accept_i             (accept_i),
  .req_reset_i          (req_reset_i),
  .req_data_abort_i     (req_data_abort_i),
  .req_fast_irq_i       (req_fast_irq_i),
  .req_irq_i            (req_irq_i),
  .req_prefetch_abort_i (req_prefetch_abort_i),
  .req_swi_i            (req_swi_i),
  .req_undef_i          (req_undef_i),
  .ret_addr_i           (ret_addr_i),
  .exc_return_i         (exc_return_i),
  .sw_we_i              (sw_we_i),
  .entry_o              (entry_o),
  .vector_o             (vector_o),
  .status_o             (status_o),
  .saved_status_o       (saved_status_o),
  .link_o               (link_o)
);

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/1ps
module exc_entry_unit_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accept = 1'b0;
  logic [6:0] rq = '0; // bit0 reset,1 dabt,2 fast,3 irq,4 pabt,5 swi,6 undef
  logic [AW-1:0] ret_addr = '0;
  logic exc_ret = 1'b0;
  logic sw_we = 1'b0;
  logic [7:0] sw_data = '0;
  logic entry;
  logic [AW-1:0] vector, link;
  logic [7:0] status, saved;
  logic [2:0] bank_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exc_entry_unit #(.ADDR_W(AW), .VEC_BASE('0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept),
    .req_reset_i(rq[0]), .req_data_abort_i(rq[1]), .req_fast_irq_i(rq[2]),
    .req_irq_i(rq[3]), .req_prefetch_abort_i(rq[4]), .req_swi_i(rq[5]),
    .req_undef_i(rq[6]), .ret_addr_i(ret_addr), .exc_return_i(exc_ret),
    .sw_we_i(sw_we), .sw_data_i(sw_data), .entry_o(entry), .vector_o(vector),
    .status_o(status), .bank_sel_o(bank_sel), .saved_status_o(saved), .link_o(link)
  );

  // {req[6:0], vector offset[4:0], mode[2:0], F}
  localparam logic [15:0] TBL [13] = '{
    {7'b0000001, 5'h00, 3'd3, 1'b1},
    {7'b0000010, 5'h10, 3'd4, 1'b0},
    {7'b0000100, 5'h1C, 3'd1, 1'b1},
    {7'b0001000, 5'h18, 3'd2, 1'b0},
    {7'b0010000, 5'h0C, 3'd4, 1'b0},
    {7'b0100000, 5'h08, 3'd3, 1'b0},
    {7'b1000000, 5'h04, 3'd5, 1'b0},
    {7'b0000110, 5'h10, 3'd4, 1'b0},
    {7'b0001100, 5'h1C, 3'd1, 1'b1},
    {7'b0111000, 5'h18, 3'd2, 1'b0},
    {7'b1110000, 5'h0C, 3'd4, 1'b0},
    {7'b1100000, 5'h04, 3'd5, 1'b0},
    {7'b1111111, 5'h00, 3'd3, 1'b1}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    accept = 1'b0; rq = '0; exc_ret = 1'b0; sw_we = 1'b0;
  endtask

  task automatic wr_status(logic [7:0] v);
    idle(); sw_we = 1'b1; sw_data = v;
    cyc();
    sw_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check("R1 status", 64'(status), 64'h C3);
    check("R1 entry", 64'(entry), 64'h0);
    check("R1 saved", 64'(saved), 64'h0);
    check("R1 link", 64'(link), 64'h0);

    // R8: both interrupt sources masked after reset
    idle(); accept = 1'b1; rq = 7'b0001100;
    cyc();
    check("R8 masked entry", 64'(entry), 64'h0);
    check("R8 masked status", 64'(status), 64'h C3);

    // R9: no sampling without accept
    idle(); rq = 7'b0000010;
    cyc();
    check("R9 no accept entry", 64'(entry), 64'h0);
    check("R9 no accept status", 64'(status), 64'h C3);

    // R3 single-cycle strobe, R7 F kept
    idle(); accept = 1'b1; rq = 7'b0000010; ret_addr = 32'h40;
    cyc();
    check("R3 strobe high", 64'(entry), 64'h1);
    check("R7 F kept", 64'(status), 64'h C4);
    check("R5 saved", 64'(saved), 64'h C3);
    idle();
    cyc();
    check("R3 strobe low", 64'(entry), 64'h0);

    // table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 13; i++) begin
      wr_status(8'h03);
      idle(); accept = 1'b1; rq = TBL[i][15:9]; ret_addr = 32'h100 + 32'(i);
      cyc();
      check("R3 entry", 64'(entry), 64'h1);
      check("R2 R3 vector", 64'(vector), 64'(TBL[i][8:4]));
      check("R4 R6 R7 status", 64'(status), 64'({1'b1, TBL[i][0], 3'b000, TBL[i][3:1]}));
      check("R4 bank", 64'(bank_sel), 64'(TBL[i][3:1]));
      check("R5 saved", 64'(saved), 64'h03);
      check("R5 link", 64'(link), 64'(32'h100 + 32'(i)));
    end

    // R12 abort and fast together
    wr_status(8'h03);
    idle(); accept = 1'b1; rq = 7'b0000110; ret_addr = 32'h200;
    cyc();
    check("R12 abort first", 64'(vector), 64'h10);
    check("R12 abort status", 64'(status), 64'h84);
    idle(); accept = 1'b1; rq = 7'b0000100; ret_addr = 32'h204;
    cyc();
    check("R12 fast next", 64'(vector), 64'h1C);
    check("R12 fast status", 64'(status), 64'h C1);
    check("R12 fast saved", 64'(saved), 64'h84);
    idle(); exc_ret = 1'b1;
    cyc();
    check("R10 return to abort", 64'(status), 64'h84);
    check("R10 abort saved", 64'(saved), 64'h03);
    cyc();
    check("R10 return masks", 64'(status), 64'h03);

    // R11 writes, R10 user return ignored
    wr_status(8'h00);
    check("R11 priv write", 64'(status), 64'h00);
    wr_status(8'hF8);
    check("R11 user write", 64'(status), 64'h38);
    idle(); exc_ret = 1'b1;
    cyc();
    check("R10 user return ignored", 64'(status), 64'h38);
    idle(); accept = 1'b1; rq = 7'b0001000; ret_addr = 32'h300;
    cyc();
    check("R8 irq taken", 64'(vector), 64'h18);
    check("R6 irq status", 64'(status), 64'h BA);
    check("R5 irq saved", 64'(saved), 64'h38);
    idle();
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule